// File: doc/BRIEF.md
# Micro-op Issue Port Dispatcher

This block sits between a scheduler window and four issue ports. Every cycle it looks at a small window of micro-op entries. Each entry has a valid bit, a class code and an age index. The block picks which entries go to which port slot and presents the choice as one-hot grant vectors. The grants are registered, so they appear on the outputs one cycle after the window contents they were computed from.

Ports 0 and 1 each have two slots per cycle:

- The first-half slot accepts a port-specific class set or an ALU micro-op.
- The second-half slot accepts only a second ALU micro-op (on port 0, a branch as well).

Port 2 takes loads, which include address generation and prefetch. Port 3 takes store-address micro-ops.

The divide unit is not pipelined. After a divide grant, the dispatcher holds further divides back for a parameterised number of cycles. Entries that get no grant remain the window owner's responsibility and are offered again in the next cycle.

Top module: `uop_port_dispatch`

## Requirements
- R1: While the synchronised reset is active, and on the first cycle after it, every grant vector is zero and `div_busy` is low.
- R2: The port 0 first-half slot accepts only these classes: ALU (0), branch (1), integer store data (2) and FP move (3). It grants at most one entry per cycle.
- R3: The port 0 second-half slot accepts only ALU (0) or branch (1), at most one per cycle.
- R4: The port 1 first-half slot accepts only these classes: FP/SIMD execute (4), divide (5), normal-speed integer (6) and ALU (0). It grants at most one entry per cycle.
- R5: The port 1 second-half slot accepts only ALU (0), at most one per cycle.
- R6: Port 2 grants at most one load-class entry (7) per cycle.
- R7: Port 3 grants at most one store-address entry (8) per cycle.
- R8: Within a slot, the entry granted is the eligible one with the smallest age value. Among equal ages, the lowest index wins.
- R9: Slots that share classes are filled in the order port 0 first half, port 0 second half, port 1 first half, port 1 second half. Each slot chooses only among entries not taken by an earlier slot.
- R10: An invalid entry is never granted, and no entry is granted to more than one slot in the same cycle.
- R11: Grant vectors are registered. They change only at a clock edge and reflect the window as it was sampled at that edge.
- R12: After a divide grant, no divide is granted for the next DIV_BUSY cycles. `div_busy` is high for exactly those cycles. Other port 1 first-half classes are not blocked during this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ent_valid | input | WIN | Valid bit per window entry |
| ent_class | input | WIN*4 | Class code per entry, entry i at bits 4i+3:4i |
| ent_age | input | WIN*AGE_W | Age per entry, smaller means older |
| gnt_p0_h1 | output | WIN | Port 0 first-half grant, one-hot or zero |
| gnt_p0_h2 | output | WIN | Port 0 second-half grant |
| gnt_p1_h1 | output | WIN | Port 1 first-half grant |
| gnt_p1_h2 | output | WIN | Port 1 second-half grant |
| gnt_p2 | output | WIN | Port 2 (load) grant |
| gnt_p3 | output | WIN | Port 3 (store address) grant |
| div_busy | output | 1 | Divide unit is still occupied by an earlier grant |

## Verification
The assertions assume that class codes outside 0 to 8 never appear on valid entries, and that the window inputs are stable around the sampling edge. The bench changes inputs only one time unit after a rising edge and uses only legal class codes. Ages may repeat, and the bench exercises that tie case on purpose. The bench keeps offering a divide entry while the unit is busy, so that the blocking window and the release cycle are both seen at the ports.

// File: rtl/uop_dispatch_pkg.sv
package uop_dispatch_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    UC_ALU  = 4'd0,
    UC_BR   = 4'd1,
    UC_STD  = 4'd2,
    UC_FMOV = 4'd3,
    UC_FEXE = 4'd4,
    UC_FDIV = 4'd5,
    UC_INT  = 4'd6,
    UC_LOAD = 4'd7,
    UC_STA  = 4'd8
  } uop_cls_e;

  // slot numbering; the first four share ALU work and are filled in this order
  localparam int SL_P0H1 = 0;
  localparam int SL_P0H2 = 1;
  localparam int SL_P1H1 = 2;
  localparam int SL_P1H2 = 3;
  localparam int SL_P2   = 4;
  localparam int SL_P3   = 5;
  localparam int N_SLOT  = 6;
  localparam int N_SHARED = 4;
endpackage

// File: rtl/uop_class_map.sv
module uop_class_map
  import uop_dispatch_pkg::*;
#(
  parameter int WIN = 8
) (
  input  logic [WIN-1:0]            valid_i,
  input  logic [WIN-1:0][CLS_W-1:0] class_i,
  input  logic                      div_busy_i,
  output logic [N_SLOT-1:0][WIN-1:0] elig_o,
  output logic [WIN-1:0]            is_div_o
);
  always_comb begin
    elig_o   = '0;
    is_div_o = '0;
    for (int i = 0; i < WIN; i++) begin
      is_div_o[i] = valid_i[i] && (class_i[i] == UC_FDIV);
      if (valid_i[i]) begin
        unique case (uop_cls_e'(class_i[i]))
          UC_ALU: begin
            elig_o[SL_P0H1][i] = 1'b1;
            elig_o[SL_P0H2][i] = 1'b1;
            elig_o[SL_P1H1][i] = 1'b1;
            elig_o[SL_P1H2][i] = 1'b1;
          end
          UC_BR: begin
            elig_o[SL_P0H1][i] = 1'b1;
            elig_o[SL_P0H2][i] = 1'b1;
          end
          UC_STD, UC_FMOV: elig_o[SL_P0H1][i] = 1'b1;
          UC_FEXE, UC_INT: elig_o[SL_P1H1][i] = 1'b1;
          UC_FDIV:         elig_o[SL_P1H1][i] = !div_busy_i;
          UC_LOAD:         elig_o[SL_P2][i]   = 1'b1;
          UC_STA:          elig_o[SL_P3][i]   = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uop_oldest_pick.sv
module uop_oldest_pick #(
  parameter int WIN   = 8,
  parameter int AGE_W = 3
) (
  input  logic [WIN-1:0]            cand_i,
  input  logic [WIN-1:0][AGE_W-1:0] age_i,
  output logic [WIN-1:0]            grant_o
);
  localparam int IDX_W = (WIN > 1) ? $clog2(WIN) : 1;

  logic             found;
  logic [IDX_W-1:0] best_idx;
  logic [AGE_W-1:0] best_age;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_age = '0;
    for (int i = 0; i < WIN; i++) begin
      if (cand_i[i] && (!found || (age_i[i] < best_age))) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_age = age_i[i];
      end
    end
    grant_o = '0;
    if (found) grant_o[best_idx] = 1'b1;
  end
endmodule

// File: rtl/uop_div_track.sv
module uop_div_track #(
  parameter int DIV_BUSY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_gnt_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(DIV_BUSY + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (div_gnt_i) begin
      cnt_d  = CNT_W'(DIV_BUSY);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/uop_port_dispatch.sv
module uop_port_dispatch
  import uop_dispatch_pkg::*;
#(
  parameter int WIN      = 8,
  parameter int AGE_W    = 3,
  parameter int DIV_BUSY = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WIN-1:0]            ent_valid,
  input  logic [WIN-1:0][3:0]       ent_class,
  input  logic [WIN-1:0][AGE_W-1:0] ent_age,
  output logic [WIN-1:0]            gnt_p0_h1,
  output logic [WIN-1:0]            gnt_p0_h2,
  output logic [WIN-1:0]            gnt_p1_h1,
  output logic [WIN-1:0]            gnt_p1_h2,
  output logic [WIN-1:0]            gnt_p2,
  output logic [WIN-1:0]            gnt_p3,
  output logic                      div_busy
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [N_SLOT-1:0][WIN-1:0]   elig;
  logic [WIN-1:0]               is_div;
  logic [N_SLOT-1:0][WIN-1:0]   pick;
  logic [N_SHARED:0][WIN-1:0]   taken;
  logic [N_SLOT-1:0][WIN-1:0]   gnt_q;
  logic                         div_gnt_d;
  logic                         gnt_en;

  uop_class_map #(.WIN(WIN)) u_map (
    .valid_i    (ent_valid),
    .class_i    (ent_class),
    .div_busy_i (div_busy),
    .elig_o     (elig),
    .is_div_o   (is_div)
  );

  // chained slots: each one sees only what earlier slots left
  assign taken[0] = '0;
  for (genvar s = 0; s < N_SHARED; s++) begin : g_shared
    uop_oldest_pick #(.WIN(WIN), .AGE_W(AGE_W)) u_pick (
      .cand_i  (elig[s] & ~taken[s]),
      .age_i   (ent_age),
      .grant_o (pick[s])
    );
    assign taken[s+1] = taken[s] | pick[s];
  end

  // memory ports have disjoint classes and pick independently
  for (genvar s = N_SHARED; s < N_SLOT; s++) begin : g_mem
    uop_oldest_pick #(.WIN(WIN), .AGE_W(AGE_W)) u_pick (
      .cand_i  (elig[s]),
      .age_i   (ent_age),
      .grant_o (pick[s])
    );
  end

  assign div_gnt_d = |(pick[SL_P1H1] & is_div);
  assign gnt_en    = 1'b1;

  uop_div_track #(.DIV_BUSY(DIV_BUSY)) u_div (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .div_gnt_i (div_gnt_d),
    .busy_o    (div_busy)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  gnt_q <= '0;
    else if (gnt_en)  gnt_q <= pick;
  end

  assign gnt_p0_h1 = gnt_q[SL_P0H1];
  assign gnt_p0_h2 = gnt_q[SL_P0H2];
  assign gnt_p1_h1 = gnt_q[SL_P1H1];
  assign gnt_p1_h2 = gnt_q[SL_P1H2];
  assign gnt_p2    = gnt_q[SL_P2];
  assign gnt_p3    = gnt_q[SL_P3];
endmodule

// File: rtl/uop_port_dispatch_chk.sv
module uop_port_dispatch_chk
  import uop_dispatch_pkg::*;
#(
  parameter int WIN = 8
) (
  input logic                      clk,
  input logic                      rst_sync_n,
  input logic [WIN-1:0]            ent_valid,
  input logic [WIN-1:0][3:0]       ent_class,
  input logic [WIN-1:0]            gnt_p0_h1,
  input logic [WIN-1:0]            gnt_p0_h2,
  input logic [WIN-1:0]            gnt_p1_h1,
  input logic [WIN-1:0]            gnt_p1_h2,
  input logic [WIN-1:0]            gnt_p2,
  input logic [WIN-1:0]            gnt_p3,
  input logic                      div_busy
);
  logic [WIN-1:0] div_mask_q;
  logic           div_now;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) div_mask_q <= '0;
    else begin
      for (int i = 0; i < WIN; i++)
        div_mask_q[i] <= ent_valid[i] && (ent_class[i] == UC_FDIV);
    end
  end
  assign div_now = |(gnt_p1_h1 & div_mask_q);

  // one grant per slot per cycle (R2..R7)
  assert_p0h1_onehot_R2: assert property (@(posedge clk) disable iff (!rst_sync_n) $onehot0(gnt_p0_h1));
  assert_p0h2_onehot_R3: assert property (@(posedge clk) disable iff (!rst_sync_n) $onehot0(gnt_p0_h2));
  assert_p1h1_onehot_R4: assert property (@(posedge clk) disable iff (!rst_sync_n) $onehot0(gnt_p1_h1));
  assert_p1h2_onehot_R5: assert property (@(posedge clk) disable iff (!rst_sync_n) $onehot0(gnt_p1_h2));
  assert_p2_onehot_R6:   assert property (@(posedge clk) disable iff (!rst_sync_n) $onehot0(gnt_p2));
  assert_p3_onehot_R7:   assert property (@(posedge clk) disable iff (!rst_sync_n) $onehot0(gnt_p3));

  for (genvar i = 0; i < WIN; i++) begin : g_ent
    assert_single_slot_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $countones({gnt_p0_h1[i], gnt_p0_h2[i], gnt_p1_h1[i], gnt_p1_h2[i], gnt_p2[i], gnt_p3[i]}) <= 1);
    assert_p0h2_class_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(rst_sync_n) || !gnt_p0_h2[i] || $past(ent_valid[i] && (ent_class[i] == UC_ALU || ent_class[i] == UC_BR)));
    assert_p1h2_class_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(rst_sync_n) || !gnt_p1_h2[i] || $past(ent_valid[i] && ent_class[i] == UC_ALU));
    assert_p2_class_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(rst_sync_n) || !gnt_p2[i] || $past(ent_valid[i] && ent_class[i] == UC_LOAD));
    assert_p3_class_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(rst_sync_n) || !gnt_p3[i] || $past(ent_valid[i] && ent_class[i] == UC_STA));
  end

  assert_div_spacing_R12: assert property (@(posedge clk) disable iff (!rst_sync_n) div_now |=> !div_now);
  assert_div_busy_set_R12: assert property (@(posedge clk) disable iff (!rst_sync_n) div_now |-> div_busy);
endmodule

bind uop_port_dispatch uop_port_dispatch_chk #(.WIN(WIN)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ent_valid  (ent_valid),
  .ent_class  (ent_class),
  .gnt_p0_h1  (gnt_p0_h1),
  .gnt_p0_h2  (gnt_p0_h2),
  .gnt_p1_h1  (gnt_p1_h1),
  .gnt_p1_h2  (gnt_p1_h2),
  .gnt_p2     (gnt_p2),
  .gnt_p3     (gnt_p3),
  .div_busy   (div_busy)
);

// File: tb/sim_uop_port_dispatch.sv
module sim_uop_port_dispatch;
  localparam int WIN = 8;
  localparam int AGE_W = 3;
  localparam int DIV_BUSY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WIN-1:0]            ent_valid = '0;
  logic [WIN-1:0][3:0]       ent_class = '0;
  logic [WIN-1:0][AGE_W-1:0] ent_age = '0;
  logic [WIN-1:0] gnt_p0_h1, gnt_p0_h2, gnt_p1_h1, gnt_p1_h2, gnt_p2, gnt_p3;
  logic div_busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles++;

  uop_port_dispatch #(.WIN(WIN), .AGE_W(AGE_W), .DIV_BUSY(DIV_BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_class(ent_class), .ent_age(ent_age),
    .gnt_p0_h1(gnt_p0_h1), .gnt_p0_h2(gnt_p0_h2), .gnt_p1_h1(gnt_p1_h1), .gnt_p1_h2(gnt_p1_h2),
    .gnt_p2(gnt_p2), .gnt_p3(gnt_p3), .div_busy(div_busy)
  );

  typedef struct packed {
    logic [7:0]  v;
    logic [31:0] c;
    logic [23:0] a;
    logic [7:0]  x0a, x0b, x1a, x1b, x2, x3;
  } vec_t;

  // ages: FAC688 means age = index, 053977 means age = 7 - index
  localparam vec_t TBL [8] = '{
    '{8'hFF, 32'h00000000, 24'hFAC688, 8'h01, 8'h02, 8'h04, 8'h08, 8'h00, 8'h00}, // all ALU, R9
    '{8'hFF, 32'h00000000, 24'h053977, 8'h80, 8'h40, 8'h20, 8'h10, 8'h00, 8'h00}, // reversed age, R8
    '{8'hFF, 32'h11438877, 24'hFAC688, 8'h10, 8'h40, 8'h20, 8'h00, 8'h01, 8'h04}, // mixed classes
    '{8'h07, 32'h00000111, 24'hFAC688, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00}, // branches port 0 only
    '{8'h1F, 32'h00003206, 24'h053977, 8'h10, 8'h02, 8'h01, 8'h00, 8'h00, 8'h00}, // int/std/fmov mix
    '{8'h00, 32'h00000000, 24'hFAC688, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, // nothing valid, R10
    '{8'hF0, 32'h00000000, 24'hFAC688, 8'h10, 8'h20, 8'h40, 8'h80, 8'h00, 8'h00}, // low half invalid, R10
    '{8'hFF, 32'h00000000, 24'h000000, 8'h01, 8'h02, 8'h04, 8'h08, 8'h00, 8'h00}  // equal ages, R8
  };

  localparam string SLOT_TAG [6] = '{"R2", "R3", "R4", "R5", "R6", "R7"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    chk("R1 grants in reset", {gnt_p0_h1, gnt_p0_h2, gnt_p1_h1, gnt_p1_h2}, 32'h0);
    chk("R1 busy in reset", {31'h0, div_busy}, 32'h0);
    ent_valid = 8'hFF;
    rst_n = 1'b1;
    step();
    chk("R1 first cycle after release", {gnt_p0_h1, gnt_p2, gnt_p3, 7'h0, div_busy}, 32'h0);
    repeat (2) step();

    // table walk: R8, R9, R10, R2..R7
    foreach (TBL[k]) begin
      ent_valid = TBL[k].v;
      ent_class = TBL[k].c;
      ent_age   = TBL[k].a;
      step();
      chk(SLOT_TAG[0], {24'h0, gnt_p0_h1}, {24'h0, TBL[k].x0a});
      chk(SLOT_TAG[1], {24'h0, gnt_p0_h2}, {24'h0, TBL[k].x0b});
      chk(SLOT_TAG[2], {24'h0, gnt_p1_h1}, {24'h0, TBL[k].x1a});
      chk(SLOT_TAG[3], {24'h0, gnt_p1_h2}, {24'h0, TBL[k].x1b});
      chk(SLOT_TAG[4], {24'h0, gnt_p2},    {24'h0, TBL[k].x2});
      chk(SLOT_TAG[5], {24'h0, gnt_p3},    {24'h0, TBL[k].x3});
    end

    // R11: a new window changes nothing before the next edge
    ent_valid = 8'h01; ent_class = '0; ent_age = '0;
    #1;
    chk("R11 output held before edge", {24'h0, gnt_p0_h1}, 32'h01);
    chk("R11 p0 second half held", {24'h0, gnt_p0_h2}, 32'h02);
    step();
    chk("R11 output after edge", {24'h0, gnt_p0_h2}, 32'h0);

    // R12: a divide entry is offered continuously
    ent_valid = 8'h01; ent_class = 32'h00000005; ent_age = '0;
    step();
    chk("R12 divide granted", {24'h0, gnt_p1_h1}, 32'h01);
    chk("R12 busy after grant", {31'h0, div_busy}, 32'h1);
    // an FP execute entry beside it is not blocked
    ent_valid = 8'h03; ent_class = 32'h00000045; ent_age = 24'hFAC688;
    step();
    chk("R12 fexe passes while busy", {24'h0, gnt_p1_h1}, 32'h02);
    ent_valid = 8'h01; ent_class = 32'h00000005;
    step();
    chk("R12 divide blocked", {24'h0, gnt_p1_h1}, 32'h0);
    chk("R12 still busy", {31'h0, div_busy}, 32'h1);
    step();
    chk("R12 blocked on last busy cycle", {24'h0, gnt_p1_h1}, 32'h0);
    chk("R12 busy cleared", {31'h0, div_busy}, 32'h0);
    step();
    chk("R12 divide granted again", {24'h0, gnt_p1_h1}, 32'h01);

    // R4 with ALU: divide blocked lets an ALU take port 1 first half after port 0
    ent_valid = 8'h0F; ent_class = 32'h00005000; ent_age = 24'hFAC688;
    step();
    chk("R4 alu in p1 while divide busy", {8'h0, gnt_p0_h1, gnt_p0_h2, gnt_p1_h1}, {8'h0, 8'h01, 8'h02, 8'h04});

    done = 1'b1;
    finish_run();
  end
endmodule